// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a broken-down calendar time (second, minute, hour, day of month, day of week, day of year, month, year) and raises an alarm interrupt when that time reaches a programmed alarm point. Software loads one alarm value per field and an 8-bit mask. A set mask bit removes its field from the comparison, so an alarm can be made to recur every minute, every day or every year by ignoring the fields that should not matter.

The interrupt is raised only when the combined comparison moves from "no match" to "match". A match that simply persists does not raise it again. Once raised, the interrupt stays high until software writes a one to the alarm bit of the interrupt location register. Setting all eight mask bits disables the alarm. A register write that brings the alarm or the mask into agreement with the current time is treated as a normal rising match and fires. The time counters that drive the inputs live outside this block.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset `alarm_irq` is 0, every alarm value is 0 and the mask is 0 (all fields compared).
- R2: With a field's mask bit clear, that field's alarm value must equal its time input for a match. Mask bit i selects field i in this order: bit 0 second, 1 minute, 2 hour, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year.
- R3: A field whose mask bit is set has no effect. A difference in that field neither blocks a match nor creates a new interrupt.
- R4: `alarm_irq` rises one clock edge after the combined match goes from 0 to 1. While the match stays at 1, no new interrupt is raised after a clear.
- R5: Once set, `alarm_irq` stays at 1 until a clock edge where `clr_en` is 1 and `clr_data[1]` is 1. That edge clears it.
- R6: A clear write with `clr_data[1]` at 0 (for example, only bit 0 set) leaves `alarm_irq` unchanged.
- R7: With all eight mask bits set, the combined match is 0 and `alarm_irq` never rises.
- R8: Register writes take effect at the clock edge where `wr_en` is 1. `wr_sel` 0 to 7 load the alarm value for field 0 to 7 (order as in R2) from the low bits of `wr_data`, and `wr_sel` 8 loads the mask from `wr_data[7:0]`. A write that turns the match from 0 to 1 fires `alarm_irq` at the following edge.
- R9: If a new rising match and an alarm clear fall on the same edge, the rising match wins and `alarm_irq` is 1.
- R10: The stored previous match state resets to "match". A time that already matches right after reset does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tm_sec | input | 6 | Current second |
| tm_min | input | 6 | Current minute |
| tm_hour | input | 5 | Current hour |
| tm_mday | input | 5 | Current day of month |
| tm_wday | input | 3 | Current day of week |
| tm_yday | input | 9 | Current day of year |
| tm_mon | input | 4 | Current month |
| tm_year | input | 12 | Current year |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select: 0-7 alarm field, 8 mask |
| wr_data | input | 12 | Register write data |
| clr_en | input | 1 | Interrupt location write strobe (write-one-to-clear) |
| clr_data | input | 2 | Interrupt location write data; bit 1 clears the alarm |
| alarm_irq | output | 1 | Alarm interrupt, held until cleared |

## Verification
If the previous-match register holds the wrong value, the alarm either fires again during a match that is still in progress or misses a true rising edge. Either error shows on `alarm_irq` one edge after the time or write that should or should not have fired. A corrupted alarm or mask register shows only when the time is moved to a point where the affected field decides the match. For that reason every field is stepped out of agreement and back on its own, and each mask bit that is exercised has its effect checked at the port. A flag that is stuck or wrongly cleared shows at the first hold cycle or the first clear write that does not target the alarm bit.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NUM_FIELDS = 8;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int MDAY_W = 5;
    localparam int WDAY_W = 3;
    localparam int YDAY_W = 9;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 12;

    // field order fixes mask bit positions: index 0 = second ... 7 = year
    localparam int FIELD_W [NUM_FIELDS] = '{SEC_W, MIN_W, HOUR_W, MDAY_W,
                                            WDAY_W, YDAY_W, MON_W, YEAR_W};

    localparam int SEL_W    = 4;
    localparam int DATA_W   = YEAR_W;
    localparam int SEL_MASK = NUM_FIELDS;
    localparam int LOC_W    = 2;
    localparam int LOC_ALARM_BIT = 1;

    function automatic int field_lsb(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += FIELD_W[k];
        return acc;
    endfunction

    localparam int TIME_W = field_lsb(NUM_FIELDS);

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [YDAY_W-1:0] yday;
        logic [WDAY_W-1:0] wday;
        logic [MDAY_W-1:0] mday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_time_t;

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    output cal_time_t             alarm_o,
    output logic [NUM_FIELDS-1:0] mask_o
);

    typedef struct packed {
        cal_time_t             alarm;
        logic [NUM_FIELDS-1:0] mask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_W'(0):        st_d.alarm.sec  = wr_data[SEC_W-1:0];
                SEL_W'(1):        st_d.alarm.min  = wr_data[MIN_W-1:0];
                SEL_W'(2):        st_d.alarm.hour = wr_data[HOUR_W-1:0];
                SEL_W'(3):        st_d.alarm.mday = wr_data[MDAY_W-1:0];
                SEL_W'(4):        st_d.alarm.wday = wr_data[WDAY_W-1:0];
                SEL_W'(5):        st_d.alarm.yday = wr_data[YDAY_W-1:0];
                SEL_W'(6):        st_d.alarm.mon  = wr_data[MON_W-1:0];
                SEL_W'(7):        st_d.alarm.year = wr_data[YEAR_W-1:0];
                SEL_W'(SEL_MASK): st_d.mask       = wr_data[NUM_FIELDS-1:0];
                default:          ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_o = st_q.alarm;
    assign mask_o  = st_q.mask;

endmodule

// File: rtl/cal_field_cmp.sv
module cal_field_cmp #(
    parameter int W = 6
) (
    input  logic [W-1:0] now_i,
    input  logic [W-1:0] alarm_i,
    input  logic         ignore_i,
    output logic         hit_o
);

    assign hit_o = ignore_i || (now_i == alarm_i);

endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic clear_i,
    output logic prev_o,
    output logic irq_o
);

    typedef struct packed {
        logic prev;
        logic irq;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d      = fl_q;
        fl_d.prev = match_i;
        if (clear_i)                 fl_d.irq = 1'b0;
        if (match_i && !fl_q.prev)   fl_d.irq = 1'b1;   // new event beats clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q.prev <= 1'b1;   // start as "matched" to suppress a reset-time edge
            fl_q.irq  <= 1'b0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign prev_o = fl_q.prev;
    assign irq_o  = fl_q.irq;

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tm_sec,
    input  logic [MIN_W-1:0]  tm_min,
    input  logic [HOUR_W-1:0] tm_hour,
    input  logic [MDAY_W-1:0] tm_mday,
    input  logic [WDAY_W-1:0] tm_wday,
    input  logic [YDAY_W-1:0] tm_yday,
    input  logic [MON_W-1:0]  tm_mon,
    input  logic [YEAR_W-1:0] tm_year,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [LOC_W-1:0]  clr_data,
    output logic              alarm_irq
);

    cal_time_t             now_t;
    cal_time_t             alarm_t;
    logic [TIME_W-1:0]     now_vec;
    logic [TIME_W-1:0]     alarm_vec;
    logic [NUM_FIELDS-1:0] mask;
    logic [NUM_FIELDS-1:0] field_hit;
    logic                  match_all;
    logic                  match_prev;
    logic                  alarm_clear;
    logic                  loc_unused;

    assign now_t     = {tm_year, tm_mon, tm_yday, tm_wday, tm_mday, tm_hour, tm_min, tm_sec};
    assign now_vec   = now_t;
    assign alarm_vec = alarm_t;

    cal_alarm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .alarm_o (alarm_t),
        .mask_o  (mask)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        localparam int LSB = field_lsb(i);
        localparam int FW  = FIELD_W[i];
        cal_field_cmp #(.W(FW)) u_cmp (
            .now_i    (now_vec[LSB +: FW]),
            .alarm_i  (alarm_vec[LSB +: FW]),
            .ignore_i (mask[i]),
            .hit_o    (field_hit[i])
        );
    end

    // all fields masked means disabled, not "always matching"
    assign match_all   = !(&mask) && (&field_hit);
    assign alarm_clear = clr_en && clr_data[LOC_ALARM_BIT];
    assign loc_unused  = ^(clr_data & ~(LOC_W'(1) << LOC_ALARM_BIT));

    cal_alarm_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match_all),
        .clear_i (alarm_clear),
        .prev_o  (match_prev),
        .irq_o   (alarm_irq)
    );

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
    import cal_alarm_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  alarm_irq,
    input logic                  clr_en,
    input logic [LOC_W-1:0]      clr_data,
    input logic                  match_all,
    input logic                  match_prev,
    input logic [NUM_FIELDS-1:0] mask
);

    logic clr_alarm;
    logic rise;
    assign clr_alarm = clr_en && clr_data[LOC_ALARM_BIT];
    assign rise      = match_all && !match_prev;

    assert_fire_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> alarm_irq);

    assert_rise_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(rise));

    assert_hold_until_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && !clr_alarm) |=> alarm_irq);

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && clr_alarm && !rise) |=> !alarm_irq);

    assert_other_bit_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq && clr_en && !clr_data[LOC_ALARM_BIT]) |=> alarm_irq);

    assert_all_masked_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !match_all);

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && clr_alarm) |=> alarm_irq);

endmodule

bind cal_alarm_cmp cal_alarm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_irq  (alarm_irq),
    .clr_en     (clr_en),
    .clr_data   (clr_data),
    .match_all  (match_all),
    .match_prev (match_prev),
    .mask       (mask)
);

// File: tb/tb_cal_alarm_cmp.sv
module tb_cal_alarm_cmp;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  tm_sec;
    logic [5:0]  tm_min;
    logic [4:0]  tm_hour;
    logic [4:0]  tm_mday;
    logic [2:0]  tm_wday;
    logic [8:0]  tm_yday;
    logic [3:0]  tm_mon;
    logic [11:0] tm_year;
    logic        wr_en;
    logic [3:0]  wr_sel;
    logic [11:0] wr_data;
    logic        clr_en;
    logic [1:0]  clr_data;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    logic [11:0] alm [8];
    logic [11:0] tv  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_alarm_cmp dut (
        .clk(clk), .rst_n(rst_n),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_mday(tm_mday),
        .tm_wday(tm_wday), .tm_yday(tm_yday), .tm_mon(tm_mon), .tm_year(tm_year),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clr_en(clr_en), .clr_data(clr_data), .alarm_irq(alarm_irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive_time();
        tm_sec  = tv[0][5:0];
        tm_min  = tv[1][5:0];
        tm_hour = tv[2][4:0];
        tm_mday = tv[3][4:0];
        tm_wday = tv[4][2:0];
        tm_yday = tv[5][8:0];
        tm_mon  = tv[6][3:0];
        tm_year = tv[7];
    endtask

    task automatic time_eq_alarm();
        for (int i = 0; i < 8; i++) tv[i] = alm[i];
        drive_time();
    endtask

    task automatic wr(input logic [3:0] sel, input logic [11:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic clr(input logic [1:0] bits);
        clr_en = 1'b1; clr_data = bits;
        tick();
        clr_en = 1'b0; clr_data = 2'b00;
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (alarm_irq !== exp) begin
            errors++;
            $display("FAIL %s: alarm_irq=%0b expected %0b", req, alarm_irq, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        clr_en = 1'b0; clr_data = '0;
        for (int i = 0; i < 8; i++) tv[i] = '0;
        drive_time();
        repeat (3) tick();
        chk(1'b0, "R1 irq low in reset");
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(1'b0, "R10 reset-time match does not fire");
        end
    endtask

    task automatic t_program_match();
        alm = '{12'd30, 12'd15, 12'd8, 12'd12, 12'd3, 12'd100, 12'd4, 12'd2024};
        time_eq_alarm();
        tv[0] = 12'd31; drive_time();
        for (int i = 0; i < 8; i++) wr(4'(i), alm[i]);
        wr(4'd8, 12'h000);
        tick();
        chk(1'b0, "R2 one field off, no match");
        tv[0] = alm[0]; drive_time();
        tick();
        chk(1'b1, "R2 full match fires");
        repeat (3) tick();
        chk(1'b1, "R5 held while uncleared");
        clr(2'b01);
        chk(1'b1, "R6 clear of bit 0 leaves alarm");
        clr(2'b10);
        chk(1'b0, "R5 bit 1 clears alarm");
        repeat (2) tick();
        chk(1'b0, "R4 continuing match does not refire");
    endtask

    task automatic t_each_field();
        for (int i = 0; i < 8; i++) begin
            tv[i] = alm[i] ^ 12'd1; drive_time();
            tick();
            chk(1'b0, $sformatf("R2 field %0d mismatch", i));
            tv[i] = alm[i]; drive_time();
            tick();
            chk(1'b1, $sformatf("R2 field %0d rematch fires", i));
            clr(2'b10);
        end
    endtask

    task automatic t_masked();
        wr(4'd8, 12'h080);
        tv[0] = alm[0] ^ 12'd1; drive_time();
        tick(); tick();
        clr(2'b10);
        tv[0] = alm[0]; tv[7] = alm[7] ^ 12'd5; drive_time();
        tick();
        chk(1'b1, "R3 masked year ignored, match fires");
        clr(2'b10);
        tv[7] = alm[7] ^ 12'd9; drive_time();
        tick();
        chk(1'b0, "R3 change of masked field gives no new alarm");
    endtask

    task automatic t_all_masked();
        wr(4'd8, 12'h0FF);
        time_eq_alarm();
        tick();
        chk(1'b0, "R7 all masked, full match silent");
        tv[0] = alm[0] ^ 12'd2; drive_time(); tick();
        tv[0] = alm[0]; drive_time(); tick();
        chk(1'b0, "R7 all masked, re-match silent");
    endtask

    task automatic t_write_edge();
        wr(4'd8, 12'h001);
        tick();
        chk(1'b1, "R8 mask write creates match edge");
        clr(2'b10);
        wr(4'd8, 12'h000);
        tv[0] = 12'd10; drive_time();
        tick();
        chk(1'b0, "R8 sec off before alarm write");
        alm[0] = 12'd10;
        wr(4'd0, alm[0]);
        chk(1'b0, "R8 write not yet visible");
        tick();
        chk(1'b1, "R8 alarm write creates match edge");
        clr(2'b10);
    endtask

    task automatic t_set_beats_clear();
        tv[2] = alm[2] ^ 12'd1; drive_time();
        tick();
        chk(1'b0, "R9 precondition no match");
        time_eq_alarm();
        clr(2'b10);
        chk(1'b1, "R9 rising match wins over clear");
        clr(2'b10);
        chk(1'b0, "R5 later clear takes effect");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_program_match();
        t_each_field();
        t_masked();
        t_all_masked();
        t_write_edge();
        t_set_beats_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule